// File: doc/BRIEF.md
# Split 16-bit Timer with Variable-Length PWM

This block is a 16-bit counter built from two 8-bit halves. A 2-bit mode field decides how the halves work together. They can run as two unrelated 8-bit reload timers. The low half can stay a timer while the high half makes an 8-bit PWM. Both halves can chain into one 16-bit reload timer. The whole 16 bits can also form a PWM whose period is 2^(9+pwmBits) counts, which gives lengths of 9 to 16 bits.

Two count enables arrive from the clock generator. One pulses once per instruction cycle and the other pulses twice per instruction cycle. In the two 16-bit modes a select chooses the faster enable, which halves the time step.

Software writes the reload and compare bytes through a small write port. It reads two sticky overflow flags, one per half, and clears them with write-one-to-clear pulses. The two flags are ORed into a single interrupt request. The PWM compare value is latched into an active register only at a period boundary.

Top module: `split_timer`

## Requirements
- R1: After reset both counters, all four byte registers and the active compare register are zero. Both flags, `irq` and `pwmOut` are 0.
- R2: In mode 0 each half counts independently.
  - On an enabled tick a half that is not at 0xFF increments.
  - A half at 0xFF instead loads its own reload byte and sets its own flag on that edge. The low half sets `ovfLo` and the high half sets `ovfHi`.
- R3: In mode 1 the low half behaves as in R2.
  - The high half counts 0x00 to 0xFF and wraps to 0x00. The edge that leaves 0xFF sets `ovfHi` and latches the compare bytes into the active compare register.
  - `pwmOut` is 1 while the high count is below the high byte of the active compare register.
- R4: In mode 2 the halves form one 16-bit count {high,low}.
  - On an enabled tick at 0xFFFF the count loads {reload high, reload low} and sets both flags.
  - On any other enabled tick the count increments, and `ovfLo` is set when the low byte was 0xFF.
- R5: In mode 3 the 16-bit count runs from 0 to 2^(9+pwmBits)−1.
  - The edge that leaves the last value returns the count to 0, sets `ovfHi` and latches the compare bytes into the active compare register. A count at or above the last value is also treated as the last value.
  - `pwmOut` is 1 while the count is below the active compare register.
- R6: In modes 0 and 1 only `tickFull` advances the count. In modes 2 and 3 the count advances on `tickHalf` when `halfRes`=1, and on `tickFull` when `halfRes`=0. The enable that is not selected has no effect.
- R7: A compare write has no effect on `pwmOut` before the next period boundary. An active compare value of zero keeps `pwmOut` at 0 for the whole period.
- R8: Each flag stays set until a cycle with its `flagClr` bit set; bit 0 clears `ovfLo` and bit 1 clears `ovfHi`. When a set event and a clear happen in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when at least one flag is set.
- R10: In modes 0 and 2 `pwmOut` is 0.
- R11: A write with `wrAddr` 0 updates the low reload byte and a write with `wrAddr` 1 updates the high reload byte. The count does not change at the write. The new value is used at the next reload, and a reload on the same edge as the write still uses the old value.
  - `wrAddr` 2 selects the compare low byte and `wrAddr` 3 selects the compare high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickFull | input | 1 | Count enable, once per instruction cycle |
| tickHalf | input | 1 | Count enable, twice per instruction cycle |
| mode | input | 2 | 0 dual timer, 1 timer plus PWM, 2 wide timer, 3 variable PWM |
| halfRes | input | 1 | Use `tickHalf` in modes 2 and 3 |
| pwmBits | input | 3 | Variable PWM length minus 9 |
| wrEn | input | 1 | Byte register write strobe |
| wrAddr | input | 2 | 0 reload low, 1 reload high, 2 compare low, 3 compare high |
| wrData | input | 8 | Write data |
| flagClr | input | 2 | Write-one-to-clear: bit 0 low flag, bit 1 high flag |
| pwmOut | output | 1 | PWM output |
| ovfLo | output | 1 | Low-half overflow flag |
| ovfHi | output | 1 | High-half overflow flag |
| irq | output | 1 | OR of both flags |

## Verification
The flag set caused by an overflow can land in the same cycle as a software clear of that flag. The bench provokes this by programming a reload of 0xFF, so the low half overflows on every tick, and holding the clear bit high while ticks run. The flag must stay at 1 throughout, and must drop only once the ticks stop.

A reload or compare write can also coincide with the reload or period boundary that consumes it. Random writes against a cycle-accurate reference model check that the old value is the one used.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL    = 2'd0,
    MODE_TMR_PWM = 2'd1,
    MODE_WIDE    = 2'd2,
    MODE_VARPWM  = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic incLo;
    logic incHi;
    logic rldLo;
    logic rldHi;
    logic zeroCnt;
    logic loadCmp;
    logic setLo;
    logic setHi;
  } tmrStrobe_t;

endpackage

// File: rtl/st_ctrl.sv
module st_ctrl
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int SEL_W  = $clog2(HALF_W)
) (
  input  logic [1:0]        mode,
  input  logic              halfRes,
  input  logic              tickFull,
  input  logic              tickHalf,
  input  logic [SEL_W-1:0]  pwmBits,
  input  logic [HALF_W-1:0] cntLo,
  input  logic [HALF_W-1:0] cntHi,
  output tmrStrobe_t        stb
);
  localparam int CNT_W = 2 * HALF_W;

  logic             tickSel;
  logic             loMax;
  logic             hiMax;
  logic [CNT_W-1:0] wideCnt;
  logic [SEL_W:0]   shiftAmt;
  logic [CNT_W-1:0] periodLast;

  assign tickSel    = (mode[1] && halfRes) ? tickHalf : tickFull;
  assign loMax      = &cntLo;
  assign hiMax      = &cntHi;
  assign wideCnt    = {cntHi, cntLo};
  assign shiftAmt   = (SEL_W + 1)'(HALF_W - 1) - {1'b0, pwmBits};
  assign periodLast = {CNT_W{1'b1}} >> shiftAmt;

  always_comb begin
    stb = '0;
    if (tickSel) begin
      case (tmrMode_e'(mode))
        MODE_DUAL: begin
          stb.incLo = !loMax;
          stb.rldLo = loMax;
          stb.setLo = loMax;
          stb.incHi = !hiMax;
          stb.rldHi = hiMax;
          stb.setHi = hiMax;
        end
        MODE_TMR_PWM: begin
          stb.incLo   = !loMax;
          stb.rldLo   = loMax;
          stb.setLo   = loMax;
          stb.incHi   = 1'b1;
          stb.setHi   = hiMax;
          stb.loadCmp = hiMax;
        end
        MODE_WIDE: begin
          if (loMax && hiMax) begin
            stb.rldLo = 1'b1;
            stb.rldHi = 1'b1;
            stb.setLo = 1'b1;
            stb.setHi = 1'b1;
          end else begin
            stb.incLo = 1'b1;
            stb.incHi = loMax;
            stb.setLo = loMax;
          end
        end
        default: begin
          if (wideCnt >= periodLast) begin
            stb.zeroCnt = 1'b1;
            stb.loadCmp = 1'b1;
            stb.setHi   = 1'b1;
          end else begin
            stb.incLo = 1'b1;
            stb.incHi = loMax;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/st_datapath.sv
module st_datapath
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [1:0]        mode,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [1:0]        flagClr,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi,
  output logic              pwmOut,
  output logic              ovfLo,
  output logic              ovfHi
);
  localparam int CNT_W = 2 * HALF_W;

  logic [3:0][HALF_W-1:0] regFile;
  logic [1:0][HALF_W-1:0] cnt;
  logic [CNT_W-1:0]       actCmp;
  logic [1:0]             flag;
  logic [1:0]             incV;
  logic [1:0]             rldV;
  logic [1:0]             setV;

  assign incV = {stb.incHi, stb.incLo};
  assign rldV = {stb.rldHi, stb.rldLo};
  assign setV = {stb.setHi, stb.setLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (wrEn) begin
      regFile[wrAddr] <= wrData;
    end
  end

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] cntQ;
      logic              flagQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cntQ  <= '0;
          flagQ <= 1'b0;
        end else begin
          if (stb.zeroCnt) begin
            cntQ <= '0;
          end else if (rldV[h]) begin
            cntQ <= regFile[h];
          end else if (incV[h]) begin
            cntQ <= cntQ + 1'b1;
          end
          flagQ <= setV[h] | (flagQ & ~flagClr[h]);
        end
      end

      assign cnt[h]  = cntQ;
      assign flag[h] = flagQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCmp <= '0;
    end else if (stb.loadCmp) begin
      actCmp <= {regFile[3], regFile[2]};
    end
  end

  always_comb begin
    case (tmrMode_e'(mode))
      MODE_TMR_PWM: pwmOut = cnt[1] < actCmp[CNT_W-1:HALF_W];
      MODE_VARPWM:  pwmOut = {cnt[1], cnt[0]} < actCmp;
      default:      pwmOut = 1'b0;
    endcase
  end

  assign cntLo = cnt[0];
  assign cntHi = cnt[1];
  assign ovfLo = flag[0];
  assign ovfHi = flag[1];

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter  int HALF_W = 8,
  localparam int SEL_W  = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickFull,
  input  logic              tickHalf,
  input  logic [1:0]        mode,
  input  logic              halfRes,
  input  logic [SEL_W-1:0]  pwmBits,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [1:0]        flagClr,
  output logic              pwmOut,
  output logic              ovfLo,
  output logic              ovfHi,
  output logic              irq
);
  tmrStrobe_t        stb;
  logic [HALF_W-1:0] cntLo;
  logic [HALF_W-1:0] cntHi;

  st_ctrl #(.HALF_W(HALF_W), .SEL_W(SEL_W)) u_ctrl (
    .mode     (mode),
    .halfRes  (halfRes),
    .tickFull (tickFull),
    .tickHalf (tickHalf),
    .pwmBits  (pwmBits),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .stb      (stb)
  );

  st_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .mode    (mode),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .flagClr (flagClr),
    .cntLo   (cntLo),
    .cntHi   (cntHi),
    .pwmOut  (pwmOut),
    .ovfLo   (ovfLo),
    .ovfHi   (ovfHi)
  );

  assign irq = ovfLo | ovfHi;

endmodule

// File: rtl/st_checker.sv
module st_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickFull,
  input logic       tickHalf,
  input logic [1:0] mode,
  input logic [1:0] flagClr,
  input logic       pwmOut,
  input logic       ovfLo,
  input logic       ovfHi
);

  AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfLo && !flagClr[0]) |=> ovfLo); // R8

  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfHi && !flagClr[1]) |=> ovfHi); // R8

  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!tickFull && !tickHalf && flagClr == 2'b00) |=> $stable({ovfLo, ovfHi})); // R6

  AST_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!mode[1] && !tickFull && flagClr == 2'b00) |=> $stable({ovfLo, ovfHi})); // R6

  AST_PWM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!mode[0]) |-> !pwmOut); // R10

  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickFull && !tickHalf) |=> ($stable(pwmOut) || mode != $past(mode))); // R7

endmodule

bind split_timer st_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickFull (tickFull),
  .tickHalf (tickHalf),
  .mode     (mode),
  .flagClr  (flagClr),
  .pwmOut   (pwmOut),
  .ovfLo    (ovfLo),
  .ovfHi    (ovfHi)
);

// File: tb/split_timer_tb.sv
module split_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickFull = 1'b0;
  logic       tickHalf = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       halfRes = 1'b0;
  logic [2:0] pwmBits = 3'd0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] flagClr = 2'd0;
  logic       pwmOut;
  logic       ovfLo;
  logic       ovfHi;
  logic       irq;

  int    errCount = 0;
  int    chkCount = 0;
  int    cycles = 0;
  string phaseTag = "R1";

  split_timer u_dut (
    .clk(clk), .rstN(rstN), .tickFull(tickFull), .tickHalf(tickHalf),
    .mode(mode), .halfRes(halfRes), .pwmBits(pwmBits), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .flagClr(flagClr),
    .pwmOut(pwmOut), .ovfLo(ovfLo), .ovfHi(ovfHi), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model built from the requirements
  logic [15:0] mCnt;
  logic [7:0]  mReg [4];
  logic [15:0] mAct;
  logic        mLo;
  logic        mHi;

  always @(posedge clk) begin
    logic       en, sLo, sHi;
    logic [7:0] lo, hi;
    logic [16:0] last;
    if (!rstN) begin
      mCnt = 16'd0; mAct = 16'd0; mLo = 1'b0; mHi = 1'b0;
      for (int i = 0; i < 4; i++) mReg[i] = 8'd0;
    end else begin
      en  = (mode >= 2'd2 && halfRes) ? tickHalf : tickFull;
      sLo = 1'b0; sHi = 1'b0;
      lo  = mCnt[7:0]; hi = mCnt[15:8];
      if (en) begin
        case (mode)
          2'd0: begin
            if (lo == 8'hFF) begin lo = mReg[0]; sLo = 1'b1; end else lo = lo + 8'd1;
            if (hi == 8'hFF) begin hi = mReg[1]; sHi = 1'b1; end else hi = hi + 8'd1;
            mCnt = {hi, lo};
          end
          2'd1: begin
            if (lo == 8'hFF) begin lo = mReg[0]; sLo = 1'b1; end else lo = lo + 8'd1;
            if (hi == 8'hFF) begin sHi = 1'b1; mAct = {mReg[3], mReg[2]}; end
            hi = hi + 8'd1;
            mCnt = {hi, lo};
          end
          2'd2: begin
            if (mCnt == 16'hFFFF) begin
              mCnt = {mReg[1], mReg[0]}; sLo = 1'b1; sHi = 1'b1;
            end else begin
              if (lo == 8'hFF) sLo = 1'b1;
              mCnt = mCnt + 16'd1;
            end
          end
          default: begin
            last = (17'd1 << (9 + pwmBits)) - 17'd1;
            if ({1'b0, mCnt} >= last) begin
              mCnt = 16'd0; mAct = {mReg[3], mReg[2]}; sHi = 1'b1;
            end else begin
              mCnt = mCnt + 16'd1;
            end
          end
        endcase
      end
      if (wrEn) mReg[wrAddr] = wrData;
      mLo = sLo | (mLo & !flagClr[0]);
      mHi = sHi | (mHi & !flagClr[1]);
    end
  end

  function automatic logic expPwm(input logic [1:0] md, input logic [15:0] c, input logic [15:0] a);
    if (md == 2'd1) return c[15:8] < a[15:8];
    if (md == 2'd3) return c < a;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    logic ePwm;
    ePwm = expPwm(mode, mCnt, mAct);
    chkCount++;
    if (pwmOut !== ePwm || ovfLo !== mLo || ovfHi !== mHi || irq !== (mLo | mHi)) begin
      errCount++;
      $display("FAIL %s outputs actual pwm=%0b lo=%0b hi=%0b irq=%0b expected pwm=%0b lo=%0b hi=%0b irq=%0b at cycle %0d",
               phaseTag, pwmOut, ovfLo, ovfHi, irq, ePwm, mLo, mHi, mLo | mHi, cycles);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic clearFlags();
    logic t;
    t = tickFull;
    tickFull = 1'b0; tickHalf = 1'b0; flagClr = 2'b11;
    cyc();
    flagClr = 2'b00; tickFull = t;
  endtask

  function automatic string modeTag(input logic [1:0] md);
    case (md)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errCount++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errCount, chkCount + 1);
      $finish;
    end
  end

  initial begin
    int pwmHigh;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", pwmOut, 1'b0, "pwmOut after reset");
    check("R1", ovfLo, 1'b0, "ovfLo after reset");
    check("R1", ovfHi, 1'b0, "ovfHi after reset");
    check("R1", irq, 1'b0, "irq after reset");

    // R2 dual timers
    phaseTag = "R2";
    mode = 2'd0;
    writeReg(2'd0, 8'hF0);
    writeReg(2'd1, 8'h80);
    tickFull = 1'b1;
    run(600);
    check("R2", ovfLo, 1'b1, "low flag after overflows");
    check("R2", ovfHi, 1'b1, "high flag after overflows");
    check("R9", irq, 1'b1, "irq with both flags");
    clearFlags();
    check("R8", ovfLo, 1'b0, "low flag cleared");
    check("R9", irq, 1'b0, "irq with no flag");

    // R11 reload change mid-run
    phaseTag = "R11";
    run(37);
    writeReg(2'd1, 8'hC0);
    run(400);

    // R8 set and clear in the same cycle
    phaseTag = "R8";
    writeReg(2'd0, 8'hFF);
    writeReg(2'd1, 8'hFF);
    run(300);
    flagClr = 2'b01;
    run(20);
    check("R8", ovfLo, 1'b1, "set wins over clear");
    tickFull = 1'b0;
    cyc();
    check("R8", ovfLo, 1'b0, "clear without set");
    flagClr = 2'b00;

    // R4 wide timer, counters sit at 0xFFFF now
    phaseTag = "R4";
    clearFlags();
    writeReg(2'd0, 8'h00);
    mode = 2'd2;
    tickFull = 1'b1;
    run(1000);
    check("R4", ovfHi, 1'b1, "wide overflow flag");

    // R10 no pwm in timer modes
    phaseTag = "R10";
    run(50);
    check("R10", pwmOut, 1'b0, "pwm in mode 2");

    // R6 half resolution ignores the full tick
    phaseTag = "R6";
    clearFlags();
    halfRes = 1'b1; tickFull = 1'b1; tickHalf = 1'b0;
    run(300);
    check("R6", ovfHi | ovfLo, 1'b0, "unselected tick ignored");
    tickHalf = 1'b1;
    run(600);
    check("R6", ovfLo, 1'b1, "half tick advances");
    halfRes = 1'b0;
    mode = 2'd0; tickFull = 1'b0; clearFlags(); tickHalf = 1'b1;
    run(300);
    check("R6", ovfLo | ovfHi, 1'b0, "half tick in mode 0");
    tickHalf = 1'b0;

    // R3 timer plus 8-bit pwm
    phaseTag = "R3";
    mode = 2'd1; tickFull = 1'b1;
    writeReg(2'd3, 8'h40);
    run(800);

    // R5 variable pwm
    phaseTag = "R5";
    mode = 2'd3; pwmBits = 3'd0;
    writeReg(2'd2, 8'hC0);
    writeReg(2'd3, 8'h00);
    run(1500);
    pwmBits = 3'd2;
    writeReg(2'd3, 8'h03);
    run(4500);

    // R7 zero compare and mid-period write
    phaseTag = "R7";
    pwmBits = 3'd0;
    writeReg(2'd2, 8'h00);
    writeReg(2'd3, 8'h00);
    run(600);
    pwmHigh = 0;
    for (int i = 0; i < 512; i++) begin
      cyc();
      if (pwmOut) pwmHigh++;
    end
    chkCount++;
    if (pwmHigh != 0) begin
      errCount++;
      $display("FAIL R7 zero compare high cycles actual=%0d expected=0", pwmHigh);
    end
    writeReg(2'd2, 8'hFF);
    run(1100);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      if (i % 2000 == 0) begin
        mode = 2'($urandom % 4);
        halfRes = 1'($urandom % 2);
        pwmBits = 3'($urandom % 3);
        phaseTag = modeTag(mode);
      end
      tickFull = ($urandom % 4) != 0;
      tickHalf = 1'($urandom % 2);
      wrEn = ($urandom % 16) == 0;
      wrAddr = 2'($urandom % 4);
      wrData = 8'($urandom);
      flagClr = (($urandom % 32) == 0) ? 2'($urandom % 4) : 2'b00;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule